// File: doc/BRIEF.md
# Four-CPU Masked Device Interrupt Router

This block collects up to 64 level-sensitive interrupt lines from devices into one shared raw request vector. Each of four CPUs owns a private 64-bit enable mask. The router drives one interrupt output per CPU. That output is high whenever the CPU's mask ANDed with the raw vector is non-zero. A separate cascade input from a legacy interrupt controller feeds one fixed position of the raw vector.

Software reaches the block through a 64-bit register port that accepts only full 8-byte accesses. Through that port it can write each CPU's mask and read back three things: the masks, the per-CPU masked requests and the raw vector. The masked request view is not stored anywhere. It is computed from the current mask and raw vector at the moment of the read. Data is little-endian: bus bit n corresponds to device line n.

Top module: `devirq_router`

## Requirements
- R1: After a synchronous reset, all four masks, the raw vector, every CPU interrupt output, `rsp_valid_o`, `rsp_err_o` and `rsp_rdata_o` are zero.
- R2: Raw bit n is registered on each clock from device line n: it is 1 the cycle after the line is sampled high and 0 the cycle after it is sampled low. It is read at offset 0x300.
- R3: The cascade input is ORed into raw bit 55, so bit 55 is set when either device line 55 or the cascade input is high.
- R4: A full-width write to a CPU's mask offset (CPU0 0x200, CPU1 0x240, CPU2 0x600, CPU3 0x640) replaces that CPU's mask only. The new value reads back at the same offset, and the other three masks are unchanged.
- R5: A read of a CPU's masked request offset (CPU0 0x280, CPU1 0x2C0, CPU2 0x680, CPU3 0x6C0) returns that CPU's mask ANDed with the raw vector, both as they stand on the request cycle.
- R6: Interrupt output i is registered. In each cycle it equals the OR-reduction of (mask i AND raw vector) from the previous cycle, so it follows both mask writes and line changes.
- R7: Writes to the masked request offsets and to the raw offset are accepted without error and change no state.
- R8: An access whose byte count `req_bytes_i` is not 8 changes no state. Its response carries `rsp_err_o`=1 and read data 0.
- R9: An access to any offset not listed in R2, R4 or R5 changes no state. Its response carries `rsp_err_o`=1 and read data 0.
- R10: Every request cycle produces `rsp_valid_o` for exactly the following cycle. Accesses that are valid under R8 and R9 respond with `rsp_err_o`=0, and write responses carry read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq_i | input | 64 | Level-sensitive device interrupt lines |
| cascade_irq_i | input | 1 | Legacy controller output, merged into raw bit 55 |
| req_valid_i | input | 1 | Register access request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset of the register |
| req_bytes_i | input | 4 | Access size in bytes (only 8 is valid) |
| req_wdata_i | input | 64 | Write data, little-endian |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | 64 | Read data |
| rsp_err_o | output | 1 | Bad size or unmapped offset |
| cpu_irq_o | output | 4 | Per-CPU interrupt outputs |

## Verification
The assertions check several rules on every cycle: the one-cycle relation between the raw vector and the line inputs (including the cascade merge into bit 55), each interrupt output against the previous cycle's masks and raw vector, the response strobe timing, the zero-data rule on errored responses, and that writes to the raw offset leave every mask unchanged. Other properties can only be shown by the bench scenarios, which compare against a behavioural model on every clock. These are: per-CPU isolation of mask writes, the exact value of masked request reads, and rejection of partial-width and unmapped accesses without side effects.

// File: rtl/devirq_pkg.sv
package devirq_pkg;
  // Register map: CPUs 0/1 sit in a low page, CPUs 2/3 in a high page.
  localparam int RAW_OFFSET = 'h300;

  function automatic int mask_offset(int cpu);
    return (((cpu / 2) != 0) ? 'h600 : 'h200) + 'h40 * (cpu % 2);
  endfunction

  function automatic int pend_offset(int cpu);
    return mask_offset(cpu) + 'h80;
  endfunction
endpackage

// File: rtl/devirq_capture.sv
module devirq_capture #(
  parameter int DATA_W      = 64,
  parameter int CASCADE_BIT = 55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] lines_i,
  input  logic              cascade_i,
  output logic [DATA_W-1:0] raw_o
);
  logic [DATA_W-1:0] merged;

  always_comb begin
    merged              = lines_i;
    merged[CASCADE_BIT] = lines_i[CASCADE_BIT] | cascade_i;
  end

  always_ff @(posedge clk) begin
    if (rst) raw_o <= '0;
    else     raw_o <= merged;
  end
endmodule

// File: rtl/devirq_cpu_slice.sv
module devirq_cpu_slice #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (mask_we_i) mask_o <= wdata_i;
      irq_o <= |(mask_o & raw_i);
    end
  end
endmodule

// File: rtl/devirq_regif.sv
module devirq_regif #(
  parameter int DATA_W   = 64,
  parameter int NUM_CPUS = 4,
  parameter int ADDR_W   = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid_i,
  input  logic                       req_write_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [3:0]                 req_bytes_i,
  input  logic [NUM_CPUS*DATA_W-1:0] mask_flat_i,
  input  logic [DATA_W-1:0]          raw_i,
  output logic [NUM_CPUS-1:0]        mask_we_o,
  output logic                       rsp_valid_o,
  output logic [DATA_W-1:0]          rsp_rdata_o,
  output logic                       rsp_err_o
);
  localparam int BUS_BYTES = DATA_W / 8;

  logic [NUM_CPUS-1:0] mask_hit, pend_hit;
  logic                raw_hit, size_ok, mapped;
  logic [DATA_W-1:0]   rd_mux;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_dec
    assign mask_hit[c]  = req_addr_i == ADDR_W'(devirq_pkg::mask_offset(c));
    assign pend_hit[c]  = req_addr_i == ADDR_W'(devirq_pkg::pend_offset(c));
    assign mask_we_o[c] = req_valid_i & req_write_i & size_ok & mask_hit[c];
  end

  assign raw_hit = req_addr_i == ADDR_W'(devirq_pkg::RAW_OFFSET);
  assign size_ok = req_bytes_i == 4'(BUS_BYTES);
  assign mapped  = (|mask_hit) | (|pend_hit) | raw_hit;

  always_comb begin
    rd_mux = raw_hit ? raw_i : '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (mask_hit[c]) rd_mux = rd_mux | mask_flat_i[c*DATA_W +: DATA_W];
      if (pend_hit[c]) rd_mux = rd_mux | (mask_flat_i[c*DATA_W +: DATA_W] & raw_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i & ~(size_ok & mapped);
      rsp_rdata_o <= (req_valid_i & ~req_write_i & size_ok & mapped) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/devirq_router.sv
module devirq_router #(
  parameter int DATA_W      = 64,
  parameter int NUM_CPUS    = 4,
  parameter int ADDR_W      = 12,
  parameter int CASCADE_BIT = 55
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   dev_irq_i,
  input  logic                cascade_irq_i,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [3:0]          req_bytes_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic                rsp_err_o,
  output logic [NUM_CPUS-1:0] cpu_irq_o
);
  logic [DATA_W-1:0]          raw_q;
  logic [NUM_CPUS*DATA_W-1:0] mask_flat;
  logic [NUM_CPUS-1:0]        mask_we;

  devirq_capture #(.DATA_W(DATA_W), .CASCADE_BIT(CASCADE_BIT)) u_capture (
    .clk(clk), .rst(rst), .lines_i(dev_irq_i), .cascade_i(cascade_irq_i),
    .raw_o(raw_q)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    devirq_cpu_slice #(.DATA_W(DATA_W)) u_slice (
      .clk(clk), .rst(rst), .mask_we_i(mask_we[c]), .wdata_i(req_wdata_i),
      .raw_i(raw_q), .mask_o(mask_flat[c*DATA_W +: DATA_W]), .irq_o(cpu_irq_o[c])
    );
  end

  devirq_regif #(.DATA_W(DATA_W), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_bytes_i(req_bytes_i), .mask_flat_i(mask_flat),
    .raw_i(raw_q), .mask_we_o(mask_we), .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o)
  );
endmodule

// File: rtl/devirq_router_chk.sv
module devirq_router_chk #(
  parameter int DATA_W      = 64,
  parameter int NUM_CPUS    = 4,
  parameter int ADDR_W      = 12,
  parameter int CASCADE_BIT = 55
) (
  input logic                       clk,
  input logic                       rst,
  input logic [DATA_W-1:0]          dev_irq_i,
  input logic                       cascade_irq_i,
  input logic                       req_valid_i,
  input logic                       req_write_i,
  input logic [ADDR_W-1:0]          req_addr_i,
  input logic                       rsp_valid_o,
  input logic [DATA_W-1:0]          rsp_rdata_o,
  input logic                       rsp_err_o,
  input logic [NUM_CPUS-1:0]        cpu_irq_o,
  input logic [NUM_CPUS*DATA_W-1:0] mask_flat,
  input logic [DATA_W-1:0]          raw_q
);
  logic [DATA_W-1:0] casc_vec;
  assign casc_vec = {{(DATA_W-1){1'b0}}, cascade_irq_i} << CASCADE_BIT;

  // R2 / R3: raw vector is last cycle's lines with the cascade merged in
  assert_raw_capture_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> raw_q == ($past(dev_irq_i) | $past(casc_vec)));

  // R6: each CPU output follows the previous cycle's masked requests
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_irq
    assert_irq_follow_R6: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |->
        cpu_irq_o[c] == |($past(mask_flat[c*DATA_W +: DATA_W]) & $past(raw_q)));
  end

  // R10: one response per request, one cycle later
  assert_rsp_timing_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o == ($past(req_valid_i) && !$past(rst)));

  // R8 / R9: errored responses carry zero data and only appear with a response
  assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_err_o |-> (rsp_valid_o && rsp_rdata_o == '0));

  // R7: writing the raw offset leaves every mask unchanged
  assert_raw_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid_i && req_write_i && !rst) &&
     $past(req_addr_i) == ADDR_W'(devirq_pkg::RAW_OFFSET)) |-> $stable(mask_flat));
endmodule

bind devirq_router devirq_router_chk #(
  .DATA_W(DATA_W), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W), .CASCADE_BIT(CASCADE_BIT)
) u_chk (
  .clk(clk), .rst(rst), .dev_irq_i(dev_irq_i), .cascade_irq_i(cascade_irq_i),
  .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
  .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
  .cpu_irq_o(cpu_irq_o), .mask_flat(mask_flat), .raw_q(raw_q)
);

// File: tb/devirq_router_bench.sv
module devirq_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] dev_irq = '0;
  logic        cascade = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_bytes = 4'd8;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [3:0]  cpu_irq;

  int vectors = 0, fails = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  devirq_router u_devirq_router (
    .clk(clk), .rst(rst), .dev_irq_i(dev_irq), .cascade_irq_i(cascade),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_bytes_i(req_bytes), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err), .cpu_irq_o(cpu_irq)
  );

  // Behavioural reference model
  logic [63:0] m_mask [4];
  logic [63:0] m_raw;
  logic [3:0]  m_irq;
  logic        m_valid, m_err;
  logic [63:0] m_rdata;
  int          kind, who;   // kind: 0 mask, 1 masked view, 2 raw, 3 unmapped

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_mask[k]) m_mask[k] = '0;
      m_raw = '0; m_irq = '0; m_valid = 0; m_err = 0; m_rdata = '0;
    end else begin
      case (req_addr)
        12'h200: begin kind = 0; who = 0; end
        12'h240: begin kind = 0; who = 1; end
        12'h600: begin kind = 0; who = 2; end
        12'h640: begin kind = 0; who = 3; end
        12'h280: begin kind = 1; who = 0; end
        12'h2C0: begin kind = 1; who = 1; end
        12'h680: begin kind = 1; who = 2; end
        12'h6C0: begin kind = 1; who = 3; end
        12'h300: begin kind = 2; who = 0; end
        default: begin kind = 3; who = 0; end
      endcase
      m_valid = req_valid;
      m_err   = req_valid && (req_bytes != 4'd8 || kind == 3);
      m_rdata = '0;
      if (req_valid && !m_err && !req_write)
        m_rdata = (kind == 0) ? m_mask[who] :
                  (kind == 1) ? (m_mask[who] & m_raw) : m_raw;
      for (int k = 0; k < 4; k++) m_irq[k] = (m_mask[k] & m_raw) != 0;
      if (req_valid && !m_err && req_write && kind == 0) m_mask[who] = req_wdata;
      m_raw = dev_irq;
      if (cascade) m_raw[55] = 1'b1;
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (rsp_valid !== m_valid || rsp_err !== m_err || rsp_rdata !== m_rdata ||
        cpu_irq !== m_irq) begin
      fails++;
      $display("FAIL %s model: actual v=%0b e=%0b d=%h irq=%b expected v=%0b e=%0b d=%h irq=%b",
               cur_req, rsp_valid, rsp_err, rsp_rdata, cpu_irq,
               m_valid, m_err, m_rdata, m_irq);
    end
  end

  task automatic access(input bit wr, input logic [11:0] a, input logic [63:0] d,
                        input logic [3:0] nb);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_bytes = nb;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_bytes = 4'd8;
  endtask

  task automatic read_chk(input logic [11:0] a, input logic [63:0] exp,
                          input bit exp_err, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_bytes = 4'd8;
    @(negedge clk);
    req_valid = 0;
    #1;
    vectors++;
    if (rsp_rdata !== exp || rsp_err !== exp_err || rsp_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s read %h: actual d=%h e=%0b expected d=%h e=%0b",
               tag, a, rsp_rdata, rsp_err, exp, exp_err);
    end
  endtask

  task automatic irq_chk(input logic [3:0] exp, input string tag);
    repeat (3) @(negedge clk);
    #1;
    vectors++;
    if (cpu_irq !== exp) begin
      fails++;
      $display("FAIL %s irq: actual %b expected %b", tag, cpu_irq, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  logic [63:0] lfsr = 64'hACE1_2345_6789_BEEF;

  initial begin
    repeat (3) @(negedge clk);
    #1;
    vectors++;
    if (cpu_irq !== 0 || rsp_valid !== 0 || rsp_rdata !== 0 || rsp_err !== 0) begin
      fails++;
      $display("FAIL R1 reset outputs: actual irq=%b v=%0b expected 0", cpu_irq, rsp_valid);
    end
    @(negedge clk); rst = 0;
    cur_req = "R1";
    read_chk(12'h300, 64'h0, 0, "R1");
    read_chk(12'h640, 64'h0, 0, "R1");

    cur_req = "R2";
    dev_irq = 64'h8000_0000_0000_0001;
    read_chk(12'h300, 64'h8000_0000_0000_0001, 0, "R2");
    dev_irq = 64'h0000_00F0_0000_0000;
    read_chk(12'h300, 64'h0000_00F0_0000_0000, 0, "R2");

    cur_req = "R3";
    dev_irq = '0; cascade = 1;
    read_chk(12'h300, 64'h0080_0000_0000_0000, 0, "R3");
    cascade = 0;
    read_chk(12'h300, 64'h0, 0, "R3");

    cur_req = "R4";
    access(1, 12'h200, 64'h0000_0000_0000_00FF, 4'd8);
    access(1, 12'h240, 64'h0080_0000_0000_0000, 4'd8);
    access(1, 12'h600, 64'hFFFF_0000_0000_0000, 4'd8);
    access(1, 12'h640, 64'h0000_0000_0001_0000, 4'd8);
    read_chk(12'h200, 64'h0000_0000_0000_00FF, 0, "R4");
    read_chk(12'h240, 64'h0080_0000_0000_0000, 0, "R4");
    read_chk(12'h600, 64'hFFFF_0000_0000_0000, 0, "R4");
    access(1, 12'h240, 64'h0000_0000_0000_0F00, 4'd8);
    read_chk(12'h200, 64'h0000_0000_0000_00FF, 0, "R4");
    read_chk(12'h640, 64'h0000_0000_0001_0000, 0, "R4");
    access(1, 12'h240, 64'h0080_0000_0000_0000, 4'd8);

    cur_req = "R5";
    dev_irq = 64'h0F00_0000_0000_0F0F;
    read_chk(12'h280, 64'h0000_0000_0000_000F, 0, "R5");
    read_chk(12'h680, 64'h0F00_0000_0000_0000, 0, "R5");
    read_chk(12'h6C0, 64'h0, 0, "R5");

    cur_req = "R6";
    irq_chk(4'b0101, "R6");
    cascade = 1;
    irq_chk(4'b0111, "R6");
    cascade = 0; dev_irq = 64'h0000_0000_0001_0000;
    irq_chk(4'b1000, "R6");
    access(1, 12'h640, 64'h0, 4'd8);
    irq_chk(4'b0000, "R6");

    cur_req = "R7";
    access(1, 12'h280, 64'hFFFF_FFFF_FFFF_FFFF, 4'd8);
    access(1, 12'h6C0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd8);
    access(1, 12'h300, 64'hFFFF_FFFF_FFFF_FFFF, 4'd8);
    read_chk(12'h200, 64'h0000_0000_0000_00FF, 0, "R7");
    read_chk(12'h240, 64'h0080_0000_0000_0000, 0, "R7");
    read_chk(12'h300, 64'h0000_0000_0001_0000, 0, "R7");

    cur_req = "R8";
    access(1, 12'h200, 64'h1234, 4'd4);
    read_chk(12'h200, 64'h0000_0000_0000_00FF, 0, "R8");
    access(0, 12'h300, 64'h0, 4'd4);

    cur_req = "R9";
    read_chk(12'h208, 64'h0, 1, "R9");
    read_chk(12'h100, 64'h0, 1, "R9");
    access(1, 12'h204, 64'hFFFF, 4'd8);
    read_chk(12'h200, 64'h0000_0000_0000_00FF, 0, "R9");

    cur_req = "R10";
    access(1, 12'h600, 64'hAAAA_5555_AAAA_5555, 4'd8);
    @(negedge clk);
    req_valid = 1; req_addr = 12'h600;
    repeat (3) @(negedge clk);
    req_valid = 0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      dev_irq = lfsr & {lfsr[31:0], lfsr[63:32]};
      cascade = lfsr[7];
      if (n % 17 == 0) begin
        req_valid = 1; req_write = lfsr[3]; req_wdata = lfsr;
        req_addr = lfsr[5] ? 12'h240 : 12'h2C0;
      end else begin
        req_valid = 0; req_write = 0;
      end
    end
    req_valid = 0; req_write = 0;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule